// File: doc/BRIEF.md
# Program-Control Instruction Sequencer

This block runs the flow-control part of an 8-bit processor. It handles six instruction forms. The first is a loop branch that decrements the B counter and branches while it is non-zero. The others are an unconditional call, a flag-conditioned call, an unconditional return, a flag-conditioned return, and a two-byte return-from-interrupt. The block holds the 16-bit program counter, the 16-bit stack pointer and the 8-bit loop counter B. It fetches opcodes and operands through a byte-wide memory port that has a combinational read path, and it pushes return addresses through the same port.

Every instruction uses a fixed schedule of machine cycles, and each machine cycle lasts a fixed number of clock cycles (T states). The schedule depends on the path taken, so a taken branch or taken call lasts longer than a skipped one. The memory address is held for the whole machine cycle. The opcode byte is sampled on the second T state of a fetch. Operand and stack bytes are sampled on the last T state of their machine cycle, and a write strobe is given on the last T state of each push cycle. Each opcode-fetch cycle is flagged on a dedicated output. The fetch of the closing byte of a return-from-interrupt gives a single-clock pulse, so that an interrupt controller can see that service has ended. A T-state index and an end-of-instruction pulse make the instruction length visible at the ports.

The reset values of PC, SP and B are parameters. The condition flags are inputs and are never modified by the block.

Top module: `branch_seq`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, PC equals RST_PC, SP equals RST_SP and B equals RST_B. In that state m1 is high, tstate is 1, and mem_wr and instr_end are low. A reset during an instruction stops it at once, and no further push write occurs.
- R2: Byte 0x10 followed by a displacement d decrements B. If the new B is non-zero, PC becomes (address after the 2-byte instruction) plus sign-extended d. This path takes 13 T states in three machine cycles of 5, 3 and 5 T states.
- R3: When the decrement of 0x10 leaves B at zero, PC moves past the 2 bytes and the instruction takes 8 T states (5 then 3). B wraps from 0 to 0xFF, which gives a taken branch.
- R4: Byte 0xCD with address bytes low then high writes the return-address high byte to SP-1 first, then the low byte to SP-2. SP then becomes SP-2 and PC becomes the target. The instruction takes 17 T states (4,3,4,3,3) and performs exactly two writes.
- R5: A conditional call has the form 11ccc100. The field ccc (bits 5:3) selects the test: 000 Z clear, 001 Z set, 010 C clear, 011 C set, 100 P/V clear, 101 P/V set, 110 S clear, 111 S set. If the test passes, the call behaves as in R4. Otherwise it reads both address bytes, moves PC by 3, leaves SP unchanged, performs no write, and takes 10 T states (4,3,3).
- R6: Byte 0xC9 loads PC low from (SP) and PC high from (SP+1), then sets SP to SP+2. It takes 10 T states (4,3,3).
- R7: A conditional return has the form 11ccc000 and uses the R5 condition encoding. If the test passes, it acts as R6 in 11 T states (5,3,3). Otherwise PC moves by 1 in 5 T states.
- R8: The byte pair 0xED 0x4D acts as R6 in 14 T states (4,4,3,3). Both fetch cycles assert m1. A reti_seen pulse lasting one clock is given during the fetch of 0x4D, and at no other time.
- R9: Any other first byte pulses illegal on its final T state and moves PC by 1 in 4 T states. The byte 0xED followed by any byte other than 0x4D pulses illegal and moves PC by 2 in 8 T states. In both cases SP and B are unchanged.
- R10: m1 is high in opcode-fetch cycles only, and every fetch cycle is also a read. mem_wr is high only on the last T state of a push cycle, and never together with m1 or mem_rd.
- R11: tstate is 1 on the first T state of every instruction and rises by one on each clock. instr_end is high on the final T state only, so tstate at instr_end equals the instruction's T-state count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_rdata | input | 8 | Read data for mem_addr (combinational memory) |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_pv | input | 1 | Parity/overflow flag |
| flag_s | input | 1 | Sign flag |
| mem_addr | output | 16 | Address held for the whole machine cycle |
| mem_wdata | output | 8 | Push data |
| mem_rd | output | 1 | Read machine cycle in progress |
| mem_wr | output | 1 | Write strobe, last T state of a push cycle |
| m1 | output | 1 | Opcode-fetch machine cycle |
| reti_seen | output | 1 | One-clock pulse while fetching the 0x4D byte of return-from-interrupt |
| illegal | output | 1 | One-clock pulse at the end of an unsupported opcode |
| instr_end | output | 1 | Final T state of the instruction |
| tstate | output | 5 | T-state index within the instruction, from 1 |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| breg | output | 8 | Loop counter B |

## Verification
A phase register in the wrong state shows up first at tstate and instr_end. The end-of-instruction pulse moves by at least one clock, so the T-state count observed at instr_end is wrong on the same instruction. A phase sequence that is wrong but has the correct length still puts the wrong value on mem_addr or mem_wr. It then shows as a misplaced or missing push, or as PC and SP values that differ from expectation one clock after instr_end. An error in condition or operand capture shows at the next instruction boundary as a wrong PC, SP or B. The fetch-cycle flags, reti_seen and illegal are counted per instruction, so an extra pulse or a missing pulse is also detected at that boundary.

// File: rtl/branch_seq_pkg.sv
package branch_seq_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2 * DATA_W;
  localparam int MT_W   = 3;   // T index inside one machine cycle
  localparam int TN_W   = 5;   // T index inside one instruction

  typedef enum logic [3:0] {
    PH_FETCH,    // opcode fetch
    PH_FETCH2,   // second fetch after prefix
    PH_OPND_LO,  // first operand byte
    PH_OPND_HI,  // second operand byte
    PH_PUSH_HI,  // write return high byte
    PH_PUSH_LO,  // write return low byte
    PH_POP_LO,   // read (SP)
    PH_POP_HI,   // read (SP+1)
    PH_REL       // relative branch add
  } phase_t;

  localparam logic [DATA_W-1:0] OP_LOOP  = 8'h10;
  localparam logic [DATA_W-1:0] OP_CALL  = 8'hCD;
  localparam logic [DATA_W-1:0] OP_RET   = 8'hC9;
  localparam logic [DATA_W-1:0] OP_PFX   = 8'hED;
  localparam logic [DATA_W-1:0] OP_IRET2 = 8'h4D;
endpackage

// File: rtl/branch_seq_rsync.sv
module branch_seq_rsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_core_n = s2_q;
endmodule

// File: rtl/branch_seq_cond.sv
module branch_seq_cond (
  input  logic [2:0] sel,
  input  logic       fz,
  input  logic       fc,
  input  logic       fpv,
  input  logic       fs,
  output logic       hit
);
  logic flag_pick;

  always_comb begin
    unique case (sel[2:1])
      2'b00:   flag_pick = fz;
      2'b01:   flag_pick = fc;
      2'b10:   flag_pick = fpv;
      default: flag_pick = fs;
    endcase
  end

  // even select tests flag clear, odd select tests flag set
  assign hit = sel[0] ? flag_pick : ~flag_pick;
endmodule

// File: rtl/branch_seq_tctr.sv
module branch_seq_tctr
  import branch_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [MT_W-1:0] len,
  input  logic            fin,
  output logic [MT_W-1:0] tc,
  output logic            mend,
  output logic [TN_W-1:0] tnum
);
  logic [MT_W-1:0] tc_d;
  logic [TN_W-1:0] tnum_d;

  assign mend = (tc == (len - MT_W'(1)));

  always_comb begin
    tc_d   = mend ? '0 : tc + MT_W'(1);
    tnum_d = fin ? TN_W'(1) : tnum + TN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc   <= '0;
      tnum <= TN_W'(1);
    end else begin
      tc   <= tc_d;
      tnum <= tnum_d;
    end
  end
endmodule

// File: rtl/branch_seq.sv
module branch_seq
  import branch_seq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RST_PC = 16'h0000,
  parameter logic [ADDR_W-1:0] RST_SP = 16'h00F0,
  parameter logic [DATA_W-1:0] RST_B  = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic              flag_pv,
  input  logic              flag_s,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              m1,
  output logic              reti_seen,
  output logic              illegal,
  output logic              instr_end,
  output logic [TN_W-1:0]   tstate,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] sp,
  output logic [DATA_W-1:0] breg
);
  localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2);

  logic            rst_core;
  logic [MT_W-1:0] len, tc;
  logic            mend, fin, bad, cc_hit;
  phase_t          ph_q, ph_d;
  logic [ADDR_W-1:0] pc_q, pc_d, sp_q, sp_d;
  logic [DATA_W-1:0] b_q, b_d, op_q, op_d, lo_q, lo_d, hi_q, hi_d;
  logic            take_q, take_d;
  logic            is_loop, is_call, is_callcc, is_ret, is_retcc, is_pfx;

  branch_seq_rsync u_rsync (.clk(clk), .rst_n(rst_n), .rst_core_n(rst_core));

  branch_seq_tctr u_tctr (
    .clk(clk), .rst_n(rst_core), .len(len), .fin(fin),
    .tc(tc), .mend(mend), .tnum(tstate)
  );

  branch_seq_cond u_cond (
    .sel(op_q[5:3]), .fz(flag_z), .fc(flag_c), .fpv(flag_pv), .fs(flag_s),
    .hit(cc_hit)
  );

  // opcode classes, valid from the third T state of the fetch onward
  assign is_loop   = (op_q == OP_LOOP);
  assign is_call   = (op_q == OP_CALL);
  assign is_ret    = (op_q == OP_RET);
  assign is_pfx    = (op_q == OP_PFX);
  assign is_callcc = (op_q[7:6] == 2'b11) && (op_q[2:0] == 3'b100);
  assign is_retcc  = (op_q[7:6] == 2'b11) && (op_q[2:0] == 3'b000);

  // machine-cycle length
  always_comb begin
    unique case (ph_q)
      PH_FETCH:   len = (is_loop || is_retcc) ? MT_W'(5) : MT_W'(4);
      PH_FETCH2:  len = MT_W'(4);
      PH_OPND_HI: len = take_q ? MT_W'(4) : MT_W'(3);
      PH_REL:     len = MT_W'(5);
      default:    len = MT_W'(3);
    endcase
  end

  // next state
  always_comb begin
    pc_d   = pc_q;
    sp_d   = sp_q;
    b_d    = b_q;
    op_d   = op_q;
    lo_d   = lo_q;
    hi_d   = hi_q;
    take_d = take_q;
    ph_d   = ph_q;
    fin    = 1'b0;
    bad    = 1'b0;
    if (ph_q == PH_FETCH && tc == MT_W'(1))  op_d = mem_rdata;
    if (ph_q == PH_FETCH2 && tc == MT_W'(1)) lo_d = mem_rdata;
    if (mend) begin
      unique case (ph_q)
        PH_FETCH: begin
          pc_d   = pc_q + STEP1;
          take_d = is_call | (is_callcc & cc_hit);
          if (is_loop) begin
            b_d  = b_q - DATA_W'(1);
            ph_d = PH_OPND_LO;
          end else if (is_call || is_callcc) begin
            ph_d = PH_OPND_LO;
          end else if (is_ret || (is_retcc && cc_hit)) begin
            ph_d = PH_POP_LO;
          end else if (is_retcc) begin
            fin = 1'b1;
          end else if (is_pfx) begin
            ph_d = PH_FETCH2;
          end else begin
            fin = 1'b1;
            bad = 1'b1;
          end
        end
        PH_FETCH2: begin
          pc_d = pc_q + STEP1;
          if (lo_q == OP_IRET2) ph_d = PH_POP_LO;
          else begin
            fin = 1'b1;
            bad = 1'b1;
          end
        end
        PH_OPND_LO: begin
          lo_d = mem_rdata;
          pc_d = pc_q + STEP1;
          if (!is_loop)           ph_d = PH_OPND_HI;
          else if (b_q == '0)     fin  = 1'b1;
          else                    ph_d = PH_REL;
        end
        PH_OPND_HI: begin
          hi_d = mem_rdata;
          pc_d = pc_q + STEP1;
          if (take_q) ph_d = PH_PUSH_HI;
          else        fin  = 1'b1;
        end
        PH_PUSH_HI: ph_d = PH_PUSH_LO;
        PH_PUSH_LO: begin
          pc_d = {hi_q, lo_q};
          sp_d = sp_q - STEP2;
          fin  = 1'b1;
        end
        PH_POP_LO: begin
          lo_d = mem_rdata;
          ph_d = PH_POP_HI;
        end
        PH_POP_HI: begin
          pc_d = {mem_rdata, lo_q};
          sp_d = sp_q + STEP2;
          fin  = 1'b1;
        end
        PH_REL: begin
          pc_d = pc_q + {{(ADDR_W-DATA_W){lo_q[DATA_W-1]}}, lo_q};
          fin  = 1'b1;
        end
        default: fin = 1'b1;
      endcase
      if (fin) ph_d = PH_FETCH;
    end
  end

  always_ff @(posedge clk or negedge rst_core) begin
    if (!rst_core) begin
      ph_q   <= PH_FETCH;
      pc_q   <= RST_PC;
      sp_q   <= RST_SP;
      b_q    <= RST_B;
      op_q   <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      take_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      pc_q   <= pc_d;
      sp_q   <= sp_d;
      b_q    <= b_d;
      op_q   <= op_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      take_q <= take_d;
    end
  end

  // bus side
  always_comb begin
    unique case (ph_q)
      PH_PUSH_HI: mem_addr = sp_q - STEP1;
      PH_PUSH_LO: mem_addr = sp_q - STEP2;
      PH_POP_LO:  mem_addr = sp_q;
      PH_POP_HI:  mem_addr = sp_q + STEP1;
      default:    mem_addr = pc_q;
    endcase
  end

  assign mem_wdata = (ph_q == PH_PUSH_HI) ? pc_q[ADDR_W-1:DATA_W] : pc_q[DATA_W-1:0];
  assign m1        = (ph_q == PH_FETCH) || (ph_q == PH_FETCH2);
  assign mem_rd    = m1 || (ph_q == PH_OPND_LO) || (ph_q == PH_OPND_HI) ||
                     (ph_q == PH_POP_LO) || (ph_q == PH_POP_HI);
  assign mem_wr    = mend && ((ph_q == PH_PUSH_HI) || (ph_q == PH_PUSH_LO));
  assign reti_seen = mend && (ph_q == PH_FETCH2) && (lo_q == OP_IRET2);
  assign illegal   = bad;
  assign instr_end = fin;
  assign pc        = pc_q;
  assign sp        = sp_q;
  assign breg      = b_q;
endmodule

// File: rtl/branch_seq_chk.sv
module branch_seq_chk (
  input logic        clk,
  input logic        rst_ok,
  input logic        instr_end,
  input logic [4:0]  tstate,
  input logic        mem_wr,
  input logic        mem_rd,
  input logic        m1,
  input logic        reti_seen,
  input logic        illegal,
  input logic [15:0] sp
);
  // R11
  end_restart_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    instr_end |=> (tstate == 5'd1));

  // R11
  tstate_step_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !instr_end |=> (tstate == $past(tstate) + 5'd1));

  // R10
  wr_alone_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    mem_wr |-> (!m1 && !mem_rd));

  // R10
  fetch_reads_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    m1 |-> mem_rd);

  // R8
  reti_in_fetch_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    reti_seen |-> (m1 && !instr_end));

  // R8
  reti_single_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    reti_seen |=> !reti_seen);

  // R9
  illegal_at_end_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    illegal |-> instr_end);

  // R4
  sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !instr_end |=> $stable(sp));
endmodule

bind branch_seq branch_seq_chk u_chk (
  .clk(clk), .rst_ok(rst_core), .instr_end(instr_end), .tstate(tstate),
  .mem_wr(mem_wr), .mem_rd(mem_rd), .m1(m1), .reti_seen(reti_seen),
  .illegal(illegal), .sp(sp)
);

// File: tb/branch_seq_tb.sv
module branch_seq_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic [7:0]  rdata;
  logic        fz, fc, fpv, fs;
  logic [15:0] mem_addr, pc, sp;
  logic [7:0]  mem_wdata, breg;
  logic        mem_rd, mem_wr, m1, reti_seen, illegal, instr_end;
  logic [4:0]  tstate;

  logic [7:0]  code_mem [0:255];
  logic [15:0] wa0, wa1;
  logic [7:0]  wd0, wd1;
  int          wr_total = 0;
  int          tests = 0;
  int          fails = 0;

  assign rdata = code_mem[mem_addr[7:0]];

  branch_seq u_dut (
    .clk(clk), .rst_n(rst_n), .mem_rdata(rdata),
    .flag_z(fz), .flag_c(fc), .flag_pv(fpv), .flag_s(fs),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .m1(m1), .reti_seen(reti_seen), .illegal(illegal), .instr_end(instr_end),
    .tstate(tstate), .pc(pc), .sp(sp), .breg(breg)
  );

  // write log: wa0/wd0 newest, wa1/wd1 the one before
  always @(posedge clk) begin
    if (mem_wr) begin
      wa1 <= wa0;  wd1 <= wd0;
      wa0 <= mem_addr; wd0 <= mem_wdata;
      wr_total <= wr_total + 1;
    end
  end

  // fields: op, byte1, byte2, stack lo, stack hi, flags {S,PV,C,Z}, expected T states
  localparam logic [51:0] VEC [0:15] = '{
    {8'h10, 8'hFE, 8'h00, 8'h00, 8'h00, 4'h0, 8'd13},  // R2 loop back
    {8'h10, 8'h05, 8'h00, 8'h00, 8'h00, 4'h0, 8'd8},   // R3 B hits zero
    {8'hCD, 8'h40, 8'h00, 8'h00, 8'h00, 4'h0, 8'd17},  // R4 call
    {8'hC4, 8'hAA, 8'h55, 8'h00, 8'h00, 4'h1, 8'd10},  // R5 NZ false
    {8'hCC, 8'h60, 8'h00, 8'h00, 8'h00, 4'h1, 8'd17},  // R5 Z true
    {8'hD0, 8'h00, 8'h00, 8'h00, 8'h00, 4'h2, 8'd5},   // R7 NC false
    {8'hD8, 8'h00, 8'h00, 8'h10, 8'h00, 4'h2, 8'd11},  // R7 C true
    {8'hE4, 8'h20, 8'h00, 8'h00, 8'h00, 4'h0, 8'd17},  // R5 PO true
    {8'hE8, 8'h00, 8'h00, 8'h00, 8'h00, 4'h0, 8'd5},   // R7 PE false
    {8'hF4, 8'h30, 8'h00, 8'h00, 8'h00, 4'h8, 8'd10},  // R5 P false
    {8'hF8, 8'h00, 8'h00, 8'h50, 8'h12, 4'h8, 8'd11},  // R7 M true
    {8'hED, 8'h4D, 8'h00, 8'h30, 8'h00, 4'h0, 8'd14},  // R8 iret
    {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 4'h0, 8'd4},   // R9 bad op
    {8'hED, 8'h00, 8'h00, 8'h00, 8'h00, 4'h0, 8'd8},   // R9 bad prefix pair
    {8'hC9, 8'h00, 8'h00, 8'h70, 8'h00, 4'h0, 8'd10},  // R6 return
    {8'h10, 8'h10, 8'h00, 8'h00, 8'h00, 4'h0, 8'd13}   // R3 wrap 0 -> FF, taken
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic cc_true(input logic [2:0] sel, input logic [3:0] f);
    logic v;
    case (sel[2:1])
      2'b00:   v = f[0];
      2'b01:   v = f[1];
      2'b10:   v = f[2];
      default: v = f[3];
    endcase
    return sel[0] ? v : !v;
  endfunction

  task automatic run_vec(input int i);
    logic [51:0] v;
    logic [7:0]  c0, c1, c2, slo, shi, eb, b0;
    logic [3:0]  fl;
    logic [15:0] pc0, sp0, epc, esp, ret;
    string       tag;
    int          et, em1, ewr, ert, eil, n_m1, n_wr, n_rt, n_il;
    logic        done, pushed;
    v   = VEC[i];
    c0  = v[51:44]; c1 = v[43:36]; c2 = v[35:28];
    slo = v[27:20]; shi = v[19:12]; fl = v[11:8]; et = int'(v[7:0]);
    pc0 = pc; sp0 = sp; b0 = breg;
    code_mem[pc0[7:0]] = c0;
    code_mem[8'(pc0[7:0] + 8'd1)] = c1;
    code_mem[8'(pc0[7:0] + 8'd2)] = c2;
    code_mem[sp0[7:0]] = slo;
    code_mem[8'(sp0[7:0] + 8'd1)] = shi;
    {fs, fpv, fc, fz} = fl;

    tag = "R9"; epc = pc0 + 16'd1; esp = sp0; eb = b0;
    em1 = 4; ewr = 0; ert = 0; eil = 0; pushed = 1'b0; ret = 16'h0;
    if (c0 == 8'h10) begin
      eb = b0 - 8'd1; em1 = 5;
      if (eb == 8'd0) begin tag = "R3"; epc = pc0 + 16'd2; end
      else begin tag = "R2"; epc = pc0 + 16'd2 + {{8{c1[7]}}, c1}; end
    end else if (c0 == 8'hCD || (c0[7:6] == 2'b11 && c0[2:0] == 3'b100)) begin
      tag = (c0 == 8'hCD) ? "R4" : "R5";
      epc = pc0 + 16'd3;
      if (c0 == 8'hCD || cc_true(c0[5:3], fl)) begin
        ret = pc0 + 16'd3; epc = {c2, c1}; esp = sp0 - 16'd2; ewr = 2; pushed = 1'b1;
      end
    end else if (c0 == 8'hC9) begin
      tag = "R6"; epc = {shi, slo}; esp = sp0 + 16'd2;
    end else if (c0[7:6] == 2'b11 && c0[2:0] == 3'b000) begin
      tag = "R7"; em1 = 5;
      if (cc_true(c0[5:3], fl)) begin epc = {shi, slo}; esp = sp0 + 16'd2; end
    end else if (c0 == 8'hED) begin
      em1 = 8; epc = pc0 + 16'd2;
      if (c1 == 8'h4D) begin tag = "R8"; ert = 1; epc = {shi, slo}; esp = sp0 + 16'd2; end
      else eil = 1;
    end else begin
      eil = 1;
    end

    n_m1 = 0; n_wr = 0; n_rt = 0; n_il = 0; done = 1'b0;
    for (int k = 0; k < 40 && !done; k++) begin
      if (k > 0) @(negedge clk);
      n_m1 += int'(m1); n_wr += int'(mem_wr); n_rt += int'(reti_seen); n_il += int'(illegal);
      if (instr_end) begin
        done = 1'b1;
        check("R11", $sformatf("%s T count op %0h", tag, c0), int'(tstate), et);
      end
    end
    if (!done) check("R11", "instr_end seen", 0, 1);
    @(negedge clk);
    check(tag, "pc", int'(pc), int'(epc));
    check(tag, "sp", int'(sp), int'(esp));
    check(tag, "B", int'(breg), int'(eb));
    check("R10", $sformatf("m1 cycles op %0h", c0), n_m1, em1);
    check("R10", $sformatf("write strobes op %0h", c0), n_wr, ewr);
    check("R8", $sformatf("reti_seen pulses op %0h", c0), n_rt, ert);
    check("R9", $sformatf("illegal pulses op %0h", c0), n_il, eil);
    if (pushed) begin
      check(tag, "push hi addr", int'(wa1), int'(sp0 - 16'd1));
      check(tag, "push hi data", int'(wd1), int'(ret[15:8]));
      check(tag, "push lo addr", int'(wa0), int'(sp0 - 16'd2));
      check(tag, "push lo data", int'(wd0), int'(ret[7:0]));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int wr_before;
    for (int a = 0; a < 256; a++) code_mem[a] = 8'h00;
    {fs, fpv, fc, fz} = 4'h0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "pc in reset", int'(pc), 16'h0000);
    check("R1", "sp in reset", int'(sp), 16'h00F0);
    check("R1", "B in reset", int'(breg), 8'h02);
    check("R1", "m1 in reset", int'(m1), 1);
    check("R1", "tstate in reset", int'(tstate), 1);
    check("R1", "mem_wr in reset", int'(mem_wr), 0);
    check("R1", "instr_end in reset", int'(instr_end), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "tstate after release", int'(tstate), 1);
    check("R1", "pc after release", int'(pc), 16'h0000);

    for (int i = 0; i < 16; i++) run_vec(i);

    // R1: reset in the middle of a call, inside the first push cycle
    code_mem[pc[7:0]] = 8'hCD;
    code_mem[8'(pc[7:0] + 8'd1)] = 8'h00;
    code_mem[8'(pc[7:0] + 8'd2)] = 8'h00;
    wr_before = wr_total;
    repeat (12) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", "pc after abort", int'(pc), 16'h0000);
    check("R1", "sp after abort", int'(sp), 16'h00F0);
    check("R1", "B after abort", int'(breg), 8'h02);
    check("R1", "tstate after abort", int'(tstate), 1);
    check("R1", "mem_wr after abort", int'(mem_wr), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "no push after abort", wr_total - wr_before, 0);
    run_vec(0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule